// File: doc/BRIEF.md
# SPI Data FIFO with Threshold and Level Checks

This block is the data buffer between a word-wide register port and an SPI shift engine. One copy serves the transmit direction and one serves the receive direction; a parameter picks which, and the choice sets the polarity of the threshold and level comparisons. Storage is counted in bytes. An entry-width setting decides whether each push or pop moves one, two or four bytes. Data leaves the FIFO in the order it entered.

An operation write controls the FIFO. One bit clears the pointers and the level, and the other bit starts or stops traffic. While the FIFO is stopped it keeps its contents. A status word reports the level, full and empty. One-cycle event pulses go to an interrupt unit: threshold reached, became full, became empty, push refused (overflow) and pop refused (underflow). Three small level-check values are compared against the fill level in 4-byte units and give three hit flags.

Top module: `spi_lvl_fifo`

## Requirements
- R1: After synchronous reset, status reads level 0 with empty=1 and full=0, `running` is 0, and every event output is 0.
- R2: Entry width code 0 moves 1 byte, code 1 moves 2 bytes, and codes 2 and 3 move 4 bytes per push or pop. `pop_data` shows the oldest entry, lowest byte first, with the bits above the entry width at zero. Entries leave in the order they were pushed.
- R3: `status[7:0]` is the stored byte count modulo 256. `status[8]` (full) is set when the free space is smaller than one entry. `status[9]` (empty) is set when less than one entry is stored.
- R4: An operation write with bit 0 set clears the level to 0. On any operation write, `running` takes the value of bit 1, so a write of 0 stops the FIFO.
- R5: While `running` is 0, pushes and pops are ignored, no overflow or underflow is flagged, and the stored data and level are kept for when the FIFO is started again.
- R6: A push while running and full is ignored, and `ovf_pulse` is 1 for the one cycle that follows.
- R7: A pop while running and empty is ignored, and `unf_pulse` is 1 for the one cycle that follows.
- R8: `thr_evt` pulses for one cycle when the byte level first meets the threshold while running. The receive variant fires at level >= threshold; the transmit variant fires at level <= threshold.
- R9: `full_evt` and `empty_evt` pulse for one cycle when full or empty becomes set while running.
- R10: `lvl_hit[i]` compares level/4 with field i of `lvl_chk` (bits [6i+5:6i]). The receive variant uses >= and the transmit variant uses <=.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_we | input | 1 | Operation write strobe |
| op_wdata | input | 2 | Bit 0 clears the FIFO, bit 1 runs it |
| width_sel | input | 2 | Entry width code |
| thresh | input | 8 | Threshold in bytes |
| lvl_chk | input | 18 | Three 6-bit level-check values |
| push | input | 1 | Push request |
| push_data | input | 32 | Data to push |
| pop | input | 1 | Pop request |
| pop_data | output | 32 | Oldest entry |
| status | output | 10 | {empty, full, level[7:0]} |
| running | output | 1 | FIFO is started |
| thr_evt | output | 1 | Threshold reached pulse |
| full_evt | output | 1 | Became-full pulse |
| empty_evt | output | 1 | Became-empty pulse |
| ovf_pulse | output | 1 | Refused push pulse |
| unf_pulse | output | 1 | Refused pop pulse |
| lvl_hit | output | 3 | Level-check comparison flags |

## Verification
The bench builds two copies of the block with a 32-byte store: a receive variant (`IS_RX=1`) and a transmit variant (`IS_RX=0`). Both copies are driven by the same inputs. With the small depth, eight word pushes reach full, so the overflow and underflow paths are covered. The same short sequence shows the threshold and level-check comparisons in both polarities. The tests cover byte, halfword and word entries, a stop and restart that must keep the data, and a clear through the operation write.

// File: rtl/spi_fifo_pkg.sv
// Shared entry-width encoding and decode helper for the SPI data FIFO.
package spi_fifo_pkg;
    typedef enum logic [1:0] {
        EW_BYTE = 2'd0,
        EW_HALF = 2'd1,
        EW_WORD = 2'd2,
        EW_WRD2 = 2'd3
    } ent_width_e;

    // Number of bytes one entry occupies for a width code.
    function automatic logic [2:0] ent_bytes(input logic [1:0] code);
        case (ent_width_e'(code))
            EW_BYTE: ent_bytes = 3'd1;
            EW_HALF: ent_bytes = 3'd2;
            default: ent_bytes = 3'd4;
        endcase
    endfunction
endpackage

// File: rtl/spi_fifo_store.sv
// Byte-addressed circular store. Pushes and pops move nbytes bytes.
// Assumes DEPTH is a power of two >= 8 and nbytes is only changed after a clear.
module spi_fifo_store #(
    parameter int DEPTH = 256,
    parameter int DW    = 32,
    localparam int AW    = $clog2(DEPTH),
    localparam int CW    = $clog2(DEPTH + 1),
    localparam int LANES = DW / 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic [2:0]    nbytes,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output logic [CW-1:0] count
);
    logic [7:0]    mem [DEPTH];
    logic [AW-1:0] wptr;
    logic [AW-1:0] rptr;

    // Write the active byte lanes at the write pointer.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            for (int k = 0; k < LANES; k++) begin
                if (3'(k) < nbytes) mem[wptr + AW'(k)] <= wdata[8*k +: 8];
            end
        end
    end

    // Advance the pointers and the byte count.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (wr_en) wptr <= wptr + AW'(nbytes);
            if (rd_en) rptr <= rptr + AW'(nbytes);
            count <= count + (wr_en ? CW'(nbytes) : CW'(0))
                           - (rd_en ? CW'(nbytes) : CW'(0));
        end
    end

    // Present the head entry, with unused lanes at zero.
    for (genvar k = 0; k < LANES; k++) begin : g_lane
        assign rdata[8*k +: 8] = (3'(k) < nbytes) ? mem[rptr + AW'(k)] : 8'h00;
    end
endmodule

// File: rtl/spi_fifo_mon.sv
// Derives full/empty from the byte count, the threshold and level-check
// comparisons (polarity chosen by IS_RX), and the rising-edge event pulses.
// Events are gated by run.
module spi_fifo_mon #(
    parameter int DEPTH = 256,
    parameter bit IS_RX = 1'b1,
    parameter int NCHK  = 3,
    parameter int CHKW  = 6,
    parameter int THW   = 8,
    localparam int CW   = $clog2(DEPTH + 1),
    localparam int MW   = ((CW > THW) ? CW : THW) + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 run,
    input  logic [CW-1:0]        count,
    input  logic [2:0]           nbytes,
    input  logic [THW-1:0]       thresh,
    input  logic [NCHK*CHKW-1:0] lvl_chk,
    output logic                 full,
    output logic                 empty,
    output logic                 thr_evt,
    output logic                 full_evt,
    output logic                 empty_evt,
    output logic [NCHK-1:0]      lvl_hit
);
    logic [MW-1:0] cnt_x;
    logic [MW-1:0] words_x;
    logic          thr_cond;
    logic          thr_q, full_q, empty_q;

    assign cnt_x   = MW'(count);
    assign words_x = cnt_x >> 2;
    assign full    = (cnt_x + MW'(nbytes)) > MW'(DEPTH);
    assign empty   = cnt_x < MW'(nbytes);

    if (IS_RX) begin : g_rx
        assign thr_cond = cnt_x >= MW'(thresh);
        for (genvar i = 0; i < NCHK; i++) begin : g_chk
            assign lvl_hit[i] = words_x >= MW'(lvl_chk[i*CHKW +: CHKW]);
        end
    end else begin : g_tx
        assign thr_cond = cnt_x <= MW'(thresh);
        for (genvar i = 0; i < NCHK; i++) begin : g_chk
            assign lvl_hit[i] = words_x <= MW'(lvl_chk[i*CHKW +: CHKW]);
        end
    end

    // Remember last-cycle conditions for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            thr_q   <= 1'b0;
            full_q  <= 1'b0;
            empty_q <= 1'b0;
        end else begin
            thr_q   <= thr_cond;
            full_q  <= full;
            empty_q <= empty;
        end
    end

    assign thr_evt   = run & thr_cond & ~thr_q;
    assign full_evt  = run & full & ~full_q;
    assign empty_evt = run & empty & ~empty_q;
endmodule

// File: rtl/spi_lvl_fifo.sv
// SPI data FIFO top. Decodes the operation write into clear and run,
// qualifies pushes and pops, and packs the status word.
// Assumes width_sel changes only together with a clear.
module spi_lvl_fifo #(
    parameter int DEPTH_BYTES = 256,
    parameter bit IS_RX       = 1'b1,
    parameter int NCHK        = 3,
    parameter int CHKW        = 6,
    parameter int THW         = 8,
    localparam int DW         = 32,
    localparam int LVLW       = 8,
    localparam int CW         = $clog2(DEPTH_BYTES + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 op_we,
    input  logic [1:0]           op_wdata,
    input  logic [1:0]           width_sel,
    input  logic [THW-1:0]       thresh,
    input  logic [NCHK*CHKW-1:0] lvl_chk,
    input  logic                 push,
    input  logic [DW-1:0]        push_data,
    input  logic                 pop,
    output logic [DW-1:0]        pop_data,
    output logic [LVLW+1:0]      status,
    output logic                 running,
    output logic                 thr_evt,
    output logic                 full_evt,
    output logic                 empty_evt,
    output logic                 ovf_pulse,
    output logic                 unf_pulse,
    output logic [NCHK-1:0]      lvl_hit
);
    import spi_fifo_pkg::*;

    logic          run_q, ovf_q, unf_q;
    logic          clr, wr_ok, rd_ok, full, empty;
    logic [2:0]    nb;
    logic [CW-1:0] count;

    assign nb    = ent_bytes(width_sel);
    assign clr   = op_we & op_wdata[0];
    assign wr_ok = run_q & push & ~full & ~clr;
    assign rd_ok = run_q & pop & ~empty & ~clr;

    // Run state and refused-access pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= 1'b0;
            ovf_q <= 1'b0;
            unf_q <= 1'b0;
        end else begin
            if (op_we) run_q <= op_wdata[1];
            ovf_q <= run_q & push & full & ~clr;
            unf_q <= run_q & pop & empty & ~clr;
        end
    end

    spi_fifo_store #(.DEPTH(DEPTH_BYTES), .DW(DW)) u_store (
        .clk(clk), .rst_n(rst_n), .clr(clr), .wr_en(wr_ok), .rd_en(rd_ok),
        .nbytes(nb), .wdata(push_data), .rdata(pop_data), .count(count)
    );

    spi_fifo_mon #(.DEPTH(DEPTH_BYTES), .IS_RX(IS_RX), .NCHK(NCHK),
                   .CHKW(CHKW), .THW(THW)) u_mon (
        .clk(clk), .rst_n(rst_n), .run(run_q), .count(count), .nbytes(nb),
        .thresh(thresh), .lvl_chk(lvl_chk), .full(full), .empty(empty),
        .thr_evt(thr_evt), .full_evt(full_evt), .empty_evt(empty_evt),
        .lvl_hit(lvl_hit)
    );

    assign status    = {empty, full, LVLW'(count)};
    assign running   = run_q;
    assign ovf_pulse = ovf_q;
    assign unf_pulse = unf_q;
endmodule

// File: rtl/spi_lvl_fifo_chk.sv
// Port-level property checker for spi_lvl_fifo, attached by bind.
module spi_lvl_fifo_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       op_we,
    input logic [1:0] op_wdata,
    input logic       push,
    input logic       pop,
    input logic [9:0] status,
    input logic       running,
    input logic       thr_evt,
    input logic       full_evt,
    input logic       ovf_pulse,
    input logic       unf_pulse
);
    // R3: full and empty never both set
    a_r3_not_full_and_empty: assert property (@(posedge clk) disable iff (!rst_n)
        !(status[8] && status[9]));

    // R4: clear empties the FIFO
    a_r4_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        (op_we && op_wdata[0]) |=> (status[7:0] == 8'd0));

    // R5: stopped FIFO keeps its level
    a_r5_stopped_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !op_we) |=> $stable(status[7:0]));

    // R6: push into full FIFO flags overflow and leaves level alone
    a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop && status[8] && running && !op_we) |=> (ovf_pulse && $stable(status[7:0])));

    // R7: pop from empty FIFO flags underflow
    a_r7_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && status[9] && running && !op_we) |=> unf_pulse);

    // R8: threshold event lasts one cycle
    a_r8_thr_single: assert property (@(posedge clk) disable iff (!rst_n)
        thr_evt |=> !thr_evt);

    // R9: full event coincides with full status
    a_r9_full_evt_flag: assert property (@(posedge clk) disable iff (!rst_n)
        full_evt |-> status[8]);
endmodule

bind spi_lvl_fifo spi_lvl_fifo_chk u_chk (
    .clk(clk), .rst_n(rst_n), .op_we(op_we), .op_wdata(op_wdata),
    .push(push), .pop(pop), .status(status), .running(running),
    .thr_evt(thr_evt), .full_evt(full_evt), .ovf_pulse(ovf_pulse),
    .unf_pulse(unf_pulse)
);

// File: tb/spi_lvl_fifo_tb.sv
// Directed bench: a receive and a transmit variant share the same stimulus.
module spi_lvl_fifo_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_we = 1'b0;
    logic [1:0]  op_wdata = 2'd0;
    logic [1:0]  width_sel = 2'd0;
    logic [7:0]  thresh = 8'd0;
    logic [17:0] lvl_chk = '0;
    logic        push = 1'b0;
    logic [31:0] push_data = '0;
    logic        pop = 1'b0;
    logic [31:0] rx_data, tx_data;
    logic [9:0]  rx_st, tx_st;
    logic        rx_run, tx_run, rx_thr, tx_thr, rx_full, tx_full, rx_emp, tx_emp;
    logic        rx_ovf, tx_ovf, rx_unf, tx_unf;
    logic [2:0]  rx_hit, tx_hit;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    spi_lvl_fifo #(.DEPTH_BYTES(32), .IS_RX(1'b1)) u_dut (
        .clk(clk), .rst_n(rst_n), .op_we(op_we), .op_wdata(op_wdata),
        .width_sel(width_sel), .thresh(thresh), .lvl_chk(lvl_chk), .push(push),
        .push_data(push_data), .pop(pop), .pop_data(rx_data), .status(rx_st),
        .running(rx_run), .thr_evt(rx_thr), .full_evt(rx_full), .empty_evt(rx_emp),
        .ovf_pulse(rx_ovf), .unf_pulse(rx_unf), .lvl_hit(rx_hit));

    spi_lvl_fifo #(.DEPTH_BYTES(32), .IS_RX(1'b0)) u_dut_tx (
        .clk(clk), .rst_n(rst_n), .op_we(op_we), .op_wdata(op_wdata),
        .width_sel(width_sel), .thresh(thresh), .lvl_chk(lvl_chk), .push(push),
        .push_data(push_data), .pop(pop), .pop_data(tx_data), .status(tx_st),
        .running(tx_run), .thr_evt(tx_thr), .full_evt(tx_full), .empty_evt(tx_emp),
        .ovf_pulse(tx_ovf), .unf_pulse(tx_unf), .lvl_hit(tx_hit));

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // One clock of stimulus; results are sampled 1 ns after the edge.
    task automatic cyc(input logic we, input logic [1:0] op, input logic ps,
                       input logic [31:0] d, input logic pp);
        @(negedge clk);
        op_we = we; op_wdata = op; push = ps; push_data = d; pop = pp;
        @(posedge clk);
        #1;
        op_we = 1'b0; op_wdata = 2'd0; push = 1'b0; pop = 1'b0;
    endtask

    task automatic t_reset;
        chk("R1 rx status", 32'(rx_st), 32'h200);
        chk("R1 tx status", 32'(tx_st), 32'h200);
        chk("R1 running", 32'({rx_run, tx_run}), 32'h0);
        chk("R1 events", 32'({rx_thr, rx_full, rx_emp, rx_ovf, rx_unf}), 32'h0);
    endtask

    task automatic t_bytes;
        width_sel = 2'd0;
        cyc(1'b1, 2'b11, 1'b0, 32'h0, 1'b0);
        chk("R4 running after start", 32'(rx_run), 32'h1);
        cyc(1'b0, 2'b00, 1'b1, 32'hFFFF_FFA1, 1'b0);
        cyc(1'b0, 2'b00, 1'b1, 32'h0000_00B2, 1'b0);
        cyc(1'b0, 2'b00, 1'b1, 32'h0000_00C3, 1'b0);
        chk("R3 byte level", 32'(rx_st), 32'h003);
        chk("R2 byte head zero-extended", rx_data, 32'h0000_00A1);
        cyc(1'b0, 2'b00, 1'b0, 32'h0, 1'b1);
        chk("R2 byte order", rx_data, 32'h0000_00B2);
        chk("R3 byte level after pop", 32'(rx_st), 32'h002);
    endtask

    task automatic t_half_word;
        width_sel = 2'd1;
        cyc(1'b1, 2'b11, 1'b0, 32'h0, 1'b0);
        cyc(1'b0, 2'b00, 1'b1, 32'hDEAD_BEEF, 1'b0);
        chk("R2 halfword data", rx_data, 32'h0000_BEEF);
        chk("R3 halfword level", 32'(rx_st), 32'h002);
        width_sel = 2'd2;
        cyc(1'b1, 2'b11, 1'b0, 32'h0, 1'b0);
        cyc(1'b0, 2'b00, 1'b1, 32'h1122_3344, 1'b0);
        cyc(1'b0, 2'b00, 1'b1, 32'h5566_7788, 1'b0);
        chk("R3 word level", 32'(rx_st), 32'h008);
        chk("R2 word head", rx_data, 32'h1122_3344);
        cyc(1'b0, 2'b00, 1'b0, 32'h0, 1'b1);
        chk("R2 word order", rx_data, 32'h5566_7788);
    endtask

    task automatic t_full_empty;
        width_sel = 2'd2;
        cyc(1'b1, 2'b11, 1'b0, 32'h0, 1'b0);
        for (int i = 0; i < 7; i++) cyc(1'b0, 2'b00, 1'b1, 32'hA000 + 32'(i), 1'b0);
        chk("R3 not full at 28 bytes", 32'(rx_st[8]), 32'h0);
        cyc(1'b0, 2'b00, 1'b1, 32'hA007, 1'b0);
        chk("R3 full status", 32'(rx_st), 32'h120);
        chk("R9 full event", 32'(rx_full), 32'h1);
        cyc(1'b0, 2'b00, 1'b1, 32'hBAD0, 1'b0);
        chk("R6 overflow pulse", 32'(rx_ovf), 32'h1);
        chk("R6 level kept", 32'(rx_st), 32'h120);
        for (int i = 0; i < 8; i++) begin
            chk("R2 drain order", rx_data, 32'hA000 + 32'(i));
            cyc(1'b0, 2'b00, 1'b0, 32'h0, 1'b1);
        end
        chk("R9 empty event", 32'(rx_emp), 32'h1);
        chk("R3 empty status", 32'(rx_st), 32'h200);
        cyc(1'b0, 2'b00, 1'b0, 32'h0, 1'b1);
        chk("R7 underflow pulse", 32'(rx_unf), 32'h1);
        chk("R7 level kept", 32'(rx_st), 32'h200);
    endtask

    task automatic t_thresh_levels;
        width_sel = 2'd2;
        thresh = 8'd12;
        lvl_chk = {6'd4, 6'd2, 6'd1};
        cyc(1'b1, 2'b11, 1'b0, 32'h0, 1'b0);
        cyc(1'b0, 2'b00, 1'b1, 32'h100, 1'b0);
        cyc(1'b0, 2'b00, 1'b1, 32'h101, 1'b0);
        chk("R8 rx below threshold", 32'(rx_thr), 32'h0);
        cyc(1'b0, 2'b00, 1'b1, 32'h102, 1'b0);
        chk("R8 rx threshold reached", 32'(rx_thr), 32'h1);
        chk("R10 rx level hits", 32'(rx_hit), 32'h3);
        chk("R10 tx level hits", 32'(tx_hit), 32'h4);
        cyc(1'b0, 2'b00, 1'b1, 32'h103, 1'b0);
        chk("R8 rx pulse single", 32'(rx_thr), 32'h0);
        cyc(1'b0, 2'b00, 1'b0, 32'h0, 1'b1);
        chk("R8 tx threshold reached", 32'(tx_thr), 32'h1);
        chk("R8 rx no refire", 32'(rx_thr), 32'h0);
    endtask

    task automatic t_stop_restart;
        cyc(1'b1, 2'b00, 1'b0, 32'h0, 1'b0);
        chk("R4 stop", 32'(rx_run), 32'h0);
        cyc(1'b0, 2'b00, 1'b1, 32'hEEEE, 1'b0);
        chk("R5 push ignored", 32'(rx_st), 32'h00C);
        cyc(1'b0, 2'b00, 1'b0, 32'h0, 1'b1);
        chk("R5 pop ignored", 32'(rx_st), 32'h00C);
        chk("R5 no pulses", 32'({rx_ovf, rx_unf}), 32'h0);
        cyc(1'b1, 2'b10, 1'b0, 32'h0, 1'b0);
        chk("R5 data kept", rx_data, 32'h101);
        chk("R5 level kept", 32'(rx_st), 32'h00C);
        cyc(1'b1, 2'b01, 1'b0, 32'h0, 1'b0);
        chk("R4 clear", 32'(rx_st), 32'h200);
        chk("R4 clear stops", 32'(rx_run), 32'h0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        t_reset();
        t_bytes();
        t_half_word();
        t_full_empty();
        t_thresh_levels();
        t_stop_restart();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule